// File: doc/BRIEF.md
# Repeating Block-Copy Bus Sequencer

This block drives the memory bus for a repeating byte-copy instruction. Once started, it runs one iteration at a time. Each iteration has the same steps:

- fetch both opcode bytes of the instruction;
- read one byte through the source pointer;
- write that byte through the destination pointer;
- step both pointers and count the byte counter down by one.

A direction input chooses whether the pointers step upward or downward.

When the counter is still non-zero after an iteration, the block does not loop internally. It spends a bus-quiet interval and moves the program counter back to the first opcode byte, so the next iteration fetches the whole instruction again. Because of this refetch, the end of every non-final iteration is an instruction boundary. An interrupt request seen there stops the sequencer with the program counter pointing back at the copy instruction. The surrounding core can then service the interrupt and later restart the sequencer from the register values it left behind.

The host loads the program counter, the pointers, the counter and the direction with a start pulse. It reads the final values from the register outputs after a completion pulse or an interrupt-acknowledge pulse.

Top module: `blkcopy_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `irq_ack`, `mem_rd`, `mem_wr` and `mem_fetch` are all low, and no bus strobe is raised while idle.
- R2: Each iteration starts with two opcode fetches of 4 cycles each. During both, `mem_rd` and `mem_fetch` are high. The first fetch uses the iteration's starting program counter and the second uses that value plus 1. The program counter advances by one after each fetch.
- R3: The fetches are followed by a 3-cycle data read at the source pointer, with `mem_rd` high and `mem_fetch` low. The byte is captured on the last read cycle.
- R4: The read is followed by a 5-cycle write at the destination pointer, with `mem_wr` high and `mem_wdata` equal to the captured byte.
- R5: Once the write completes, and not before, both pointers step by +1 when `dir_down` is 0 or by -1 when it is 1, wrapping modulo 65536.
- R6: The counter decrements by one at the same moment. A starting count of 0 wraps to 0xFFFF, which gives a 65536-byte copy.
- R7: If the decremented counter is non-zero, the block runs 5 cycles with no strobe and then moves the program counter back by 2. A repeating iteration therefore lasts 21 cycles.
- R8: If the decremented counter is zero, the iteration ends after 16 cycles. `done` pulses for one cycle, `busy` falls, and `pc_out` is left at the starting program counter plus 2.
- R9: `irq` is sampled only on the last quiet cycle of a repeating iteration. If it is high there, the block stops, `irq_ack` pulses for one cycle, `pc_out` points back at the copy instruction, and a later start from the output registers completes the copy.
- R10: `irq` has no effect during the final iteration: that iteration ends with `done` and without `irq_ack`.
- R11: `mem_wr` is never high together with `mem_rd` or `mem_fetch`, and `mem_fetch` is high only during the two fetch phases, so fetches make up half of all bus accesses.
- R12: `start` is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Load the register inputs and begin an iteration (when idle) |
| dir_down | input | 1 | 0: pointers step up, 1: pointers step down |
| pc_in | input | 16 | Address of the first opcode byte |
| src_in | input | 16 | Source pointer |
| dst_in | input | 16 | Destination pointer |
| cnt_in | input | 16 | Byte counter |
| irq | input | 1 | Interrupt request |
| mem_rdata | input | 8 | Read data from memory |
| mem_addr | output | 16 | Bus address |
| mem_wdata | output | 8 | Write data |
| mem_rd | output | 1 | Read strobe (fetch or data read) |
| mem_wr | output | 1 | Write strobe |
| mem_fetch | output | 1 | Marks an opcode fetch |
| busy | output | 1 | Sequencer active |
| done | output | 1 | One-cycle pulse when the counter reaches zero |
| irq_ack | output | 1 | One-cycle pulse when an interrupt stops the copy |
| pc_out | output | 16 | Current program counter |
| src_out | output | 16 | Current source pointer |
| dst_out | output | 16 | Current destination pointer |
| cnt_out | output | 16 | Current byte counter |

## Verification
The embedded assertions cover properties that must hold on every cycle:

- fetch addresses follow the program counter, and data-read addresses follow the source pointer;
- write data and address stay stable through the write;
- the strobes are mutually exclusive, and nothing is strobed while idle;
- pointers and counter change only right after a write, with the counter dropping by exactly one;
- the program counter moves back by two at the end of every quiet interval;
- an acknowledge only ever comes with a non-zero counter.

Other behaviours are only visible to the bench's scenarios. These are:

- the exact phase and iteration lengths;
- the copied memory contents in both directions and across the address wrap;
- the full-length count from zero;
- where interrupts are sampled, including pulses that miss the sampling point and requests during the final iteration;
- that a copy resumed after an interrupt finishes correctly;
- that a start during a run changes nothing.

// File: rtl/blkcopy_pkg.sv
package blkcopy_pkg;
    parameter int unsigned ADDR_W = 16;
    parameter int unsigned DATA_W = 8;
    parameter int unsigned TICK_W = 4;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_FETCH1 = 3'd1,
        PH_FETCH2 = 3'd2,
        PH_READ   = 3'd3,
        PH_WRITE  = 3'd4,
        PH_GAP    = 3'd5
    } phase_e;

    typedef struct packed {
        phase_e              phase;
        logic [TICK_W-1:0]   tick;
        logic [ADDR_W-1:0]   pc;
        logic [ADDR_W-1:0]   src;
        logic [ADDR_W-1:0]   dst;
        logic [ADDR_W-1:0]   cnt;
        logic [DATA_W-1:0]   data;
        logic                down;
        logic                done;
        logic                ack;
    } seq_state_t;
endpackage

// File: rtl/blkcopy_step.sv
module blkcopy_step #(
    parameter int unsigned AW = 16
) (
    input  logic [AW-1:0] src_i,
    input  logic [AW-1:0] dst_i,
    input  logic [AW-1:0] cnt_i,
    input  logic          down_i,
    output logic [AW-1:0] src_o,
    output logic [AW-1:0] dst_o,
    output logic [AW-1:0] cnt_o,
    output logic          last_o
);
    localparam logic [AW-1:0] ONE = AW'(1);

    always_comb begin
        src_o  = down_i ? (src_i - ONE) : (src_i + ONE);
        dst_o  = down_i ? (dst_i - ONE) : (dst_i + ONE);
        cnt_o  = cnt_i - ONE;
        last_o = (cnt_o == '0);
    end
endmodule

// File: rtl/blkcopy_bus_dec.sv
module blkcopy_bus_dec
    import blkcopy_pkg::*;
#(
    parameter int unsigned AW = 16,
    parameter int unsigned DW = 8
) (
    input  phase_e        phase_i,
    input  logic [AW-1:0] pc_i,
    input  logic [AW-1:0] src_i,
    input  logic [AW-1:0] dst_i,
    input  logic [DW-1:0] data_i,
    output logic [AW-1:0] addr_o,
    output logic [DW-1:0] wdata_o,
    output logic          rd_o,
    output logic          wr_o,
    output logic          fetch_o
);
    always_comb begin
        addr_o  = '0;
        wdata_o = '0;
        rd_o    = 1'b0;
        wr_o    = 1'b0;
        fetch_o = 1'b0;
        case (phase_i)
            PH_FETCH1, PH_FETCH2: begin
                addr_o  = pc_i;
                rd_o    = 1'b1;
                fetch_o = 1'b1;
            end
            PH_READ: begin
                addr_o = src_i;
                rd_o   = 1'b1;
            end
            PH_WRITE: begin
                addr_o  = dst_i;
                wdata_o = data_i;
                wr_o    = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/blkcopy_seq.sv
module blkcopy_seq
    import blkcopy_pkg::*;
#(
    parameter int unsigned FETCH_CYC = 4,
    parameter int unsigned READ_CYC  = 3,
    parameter int unsigned WRITE_CYC = 5,
    parameter int unsigned GAP_CYC   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              dir_down,
    input  logic [ADDR_W-1:0] pc_in,
    input  logic [ADDR_W-1:0] src_in,
    input  logic [ADDR_W-1:0] dst_in,
    input  logic [ADDR_W-1:0] cnt_in,
    input  logic              irq,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              mem_fetch,
    output logic              busy,
    output logic              done,
    output logic              irq_ack,
    output logic [ADDR_W-1:0] pc_out,
    output logic [ADDR_W-1:0] src_out,
    output logic [ADDR_W-1:0] dst_out,
    output logic [ADDR_W-1:0] cnt_out
);
    localparam logic [TICK_W-1:0] FETCH_LAST = TICK_W'(FETCH_CYC - 1);
    localparam logic [TICK_W-1:0] READ_LAST  = TICK_W'(READ_CYC - 1);
    localparam logic [TICK_W-1:0] WRITE_LAST = TICK_W'(WRITE_CYC - 1);
    localparam logic [TICK_W-1:0] GAP_LAST   = TICK_W'(GAP_CYC - 1);
    localparam logic [ADDR_W-1:0] OP_BYTES   = ADDR_W'(2);

    seq_state_t s_d, s_q;

    logic [TICK_W-1:0] last_tick_d;
    logic              at_last_d;
    logic [ADDR_W-1:0] src_nx_d, dst_nx_d, cnt_nx_d;
    logic              cnt_zero_d;

    blkcopy_step #(.AW(ADDR_W)) step_i (
        .src_i  (s_q.src),
        .dst_i  (s_q.dst),
        .cnt_i  (s_q.cnt),
        .down_i (s_q.down),
        .src_o  (src_nx_d),
        .dst_o  (dst_nx_d),
        .cnt_o  (cnt_nx_d),
        .last_o (cnt_zero_d)
    );

    blkcopy_bus_dec #(.AW(ADDR_W), .DW(DATA_W)) dec_i (
        .phase_i (s_q.phase),
        .pc_i    (s_q.pc),
        .src_i   (s_q.src),
        .dst_i   (s_q.dst),
        .data_i  (s_q.data),
        .addr_o  (mem_addr),
        .wdata_o (mem_wdata),
        .rd_o    (mem_rd),
        .wr_o    (mem_wr),
        .fetch_o (mem_fetch)
    );

    // Length of the current phase.
    always_comb begin
        case (s_q.phase)
            PH_FETCH1, PH_FETCH2: last_tick_d = FETCH_LAST;
            PH_READ:              last_tick_d = READ_LAST;
            PH_WRITE:             last_tick_d = WRITE_LAST;
            PH_GAP:               last_tick_d = GAP_LAST;
            default:              last_tick_d = '0;
        endcase
        at_last_d = (s_q.tick == last_tick_d);
    end

    // Next-state process.
    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        s_d.ack  = 1'b0;
        if (s_q.phase == PH_IDLE) begin
            if (start) begin
                s_d.phase = PH_FETCH1;
                s_d.tick  = '0;
                s_d.pc    = pc_in;
                s_d.src   = src_in;
                s_d.dst   = dst_in;
                s_d.cnt   = cnt_in;
                s_d.down  = dir_down;
            end
        end else if (!at_last_d) begin
            s_d.tick = s_q.tick + TICK_W'(1);
        end else begin
            s_d.tick = '0;
            case (s_q.phase)
                PH_FETCH1: begin
                    s_d.pc    = s_q.pc + ADDR_W'(1);
                    s_d.phase = PH_FETCH2;
                end
                PH_FETCH2: begin
                    s_d.pc    = s_q.pc + ADDR_W'(1);
                    s_d.phase = PH_READ;
                end
                PH_READ: begin
                    s_d.data  = mem_rdata;
                    s_d.phase = PH_WRITE;
                end
                PH_WRITE: begin
                    s_d.src = src_nx_d;
                    s_d.dst = dst_nx_d;
                    s_d.cnt = cnt_nx_d;
                    if (cnt_zero_d) begin
                        s_d.phase = PH_IDLE;
                        s_d.done  = 1'b1;
                    end else begin
                        s_d.phase = PH_GAP;
                    end
                end
                PH_GAP: begin
                    s_d.pc = s_q.pc - OP_BYTES;
                    if (irq) begin
                        s_d.phase = PH_IDLE;
                        s_d.ack   = 1'b1;
                    end else begin
                        s_d.phase = PH_FETCH1;
                    end
                end
                default: s_d.phase = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy    = (s_q.phase != PH_IDLE);
    assign done    = s_q.done;
    assign irq_ack = s_q.ack;
    assign pc_out  = s_q.pc;
    assign src_out = s_q.src;
    assign dst_out = s_q.dst;
    assign cnt_out = s_q.cnt;

    // Assertions
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_rd && !mem_wr && !mem_fetch)); // R1
    AST_FETCH_AT_PC: assert property (@(posedge clk) disable iff (!rst_n)
        mem_fetch |-> (mem_addr == pc_out && mem_rd)); // R2
    AST_READ_AT_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && !mem_fetch) |-> (mem_addr == src_out)); // R3
    AST_WRITE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && $past(mem_wr)) |-> ($stable(mem_wdata) && $stable(mem_addr))); // R4
    AST_PTR_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && !$past(mem_wr)) |-> ($stable(src_out) && $stable(dst_out) && $stable(cnt_out))); // R5
    AST_CNT_DEC_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mem_wr) && !mem_wr) |-> (cnt_out == $past(cnt_out) - ADDR_W'(1))); // R6
    AST_PC_REWIND: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase == PH_GAP && at_last_d) |=> (pc_out == $past(pc_out) - OP_BYTES)); // R7
    AST_ACK_NONFINAL: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |-> (cnt_out != '0 && !busy && !done)); // R10
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (!mem_rd && !mem_fetch)); // R11
    AST_NO_RELOAD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && busy && s_q.phase == PH_FETCH1 && s_q.tick == '0) |-> (s_q.pc == $past(s_q.pc) - OP_BYTES)); // R12
endmodule

// File: tb/blkcopy_seq_tb.sv
module blkcopy_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        dir_down = 1'b0;
    logic [15:0] pc_in = '0, src_in = '0, dst_in = '0, cnt_in = '0;
    logic        irq = 1'b0;
    logic [7:0]  mem_rdata;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_rd, mem_wr, mem_fetch, busy, done, irq_ack;
    logic [15:0] pc_out, src_out, dst_out, cnt_out;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    blkcopy_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .dir_down(dir_down),
        .pc_in(pc_in), .src_in(src_in), .dst_in(dst_in), .cnt_in(cnt_in),
        .irq(irq), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_fetch(mem_fetch), .busy(busy), .done(done), .irq_ack(irq_ack),
        .pc_out(pc_out), .src_out(src_out), .dst_out(dst_out), .cnt_out(cnt_out)
    );

    // Small memory model, indexed by the low address byte.
    logic [7:0] mem [256];
    assign mem_rdata = mem[mem_addr[7:0]];
    always @(posedge clk) if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;

    function automatic logic [7:0] pat(input int i);
        return 8'(i) ^ 8'hA5;
    endfunction

    task automatic init_mem();
        for (int i = 0; i < 256; i++) mem[i] = pat(i);
    endtask

    // Bus monitor, sampled on the falling edge.
    int m_fetch, m_rd, m_wr, m_gap, m_busy, m_bad, m_badfa, m_done, m_ack;
    logic [15:0] run_pc;

    task automatic clr_mon(input logic [15:0] pc);
        m_fetch = 0; m_rd = 0; m_wr = 0; m_gap = 0; m_busy = 0;
        m_bad = 0; m_badfa = 0; m_done = 0; m_ack = 0; run_pc = pc;
    endtask

    always @(negedge clk) begin
        if (busy) m_busy++;
        if (mem_fetch) begin
            m_fetch++;
            if (mem_addr != run_pc && mem_addr != run_pc + 16'd1) m_badfa++;
        end
        if (mem_rd && !mem_fetch) m_rd++;
        if (mem_wr) m_wr++;
        if (busy && !mem_rd && !mem_wr) m_gap++;
        if ((mem_wr && (mem_rd || mem_fetch)) || (mem_fetch && !mem_rd)) m_bad++;
        if (!busy && (mem_rd || mem_wr)) m_bad++;
        if (done) m_done++;
        if (irq_ack) m_ack++;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic pulse_start(input logic [15:0] pc, src, dst, cnt, input logic dn);
        @(negedge clk);
        pc_in = pc; src_in = src; dst_in = dst; cnt_in = cnt; dir_down = dn;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_end();
        while (!(done || irq_ack)) @(negedge clk);
        #1;
    endtask

    task automatic run(input logic [15:0] pc, src, dst, cnt, input logic dn);
        clr_mon(pc);
        pulse_start(pc, src, dst, cnt, dn);
        wait_end();
    endtask

    task automatic t_reset();
        chk("R1 busy", busy, 0);
        chk("R1 strobes", {mem_rd, mem_wr, mem_fetch}, 0);
        chk("R1 pulses", {done, irq_ack}, 0);
    endtask

    task automatic t_copy_up();
        init_mem();
        run(16'h0080, 16'h0010, 16'h0040, 16'd3, 1'b0);
        chk("R7 R8 busy cycles", m_busy, 58);
        chk("R2 fetch cycles", m_fetch, 24);
        chk("R2 fetch address", m_badfa, 0);
        chk("R3 read cycles", m_rd, 9);
        chk("R4 write cycles", m_wr, 15);
        chk("R7 quiet cycles", m_gap, 10);
        chk("R11 strobe mix", m_bad, 0);
        for (int i = 0; i < 3; i++) chk("R4 copied byte", mem[8'h40 + i], pat(16 + i));
        chk("R5 src up", src_out, 16'h0013);
        chk("R5 dst up", dst_out, 16'h0043);
        chk("R6 count", cnt_out, 0);
        chk("R8 pc", pc_out, 16'h0082);
        chk("R8 done once", m_done, 1);
        chk("R8 idle", busy, 0);
    endtask

    task automatic t_copy_down();
        init_mem();
        run(16'h0090, 16'h002F, 16'h005F, 16'd2, 1'b1);
        chk("R5 down byte0", mem[8'h5F], pat(8'h2F));
        chk("R5 down byte1", mem[8'h5E], pat(8'h2E));
        chk("R5 src down", src_out, 16'h002D);
        chk("R5 dst down", dst_out, 16'h005D);
        chk("R7 busy down", m_busy, 37);
    endtask

    task automatic t_wrap();
        init_mem();
        run(16'h0070, 16'hFFFF, 16'h00FE, 16'd1, 1'b0);
        chk("R5 src wraps up", src_out, 16'h0000);
        chk("R4 wrap byte", mem[8'hFE], pat(8'hFF));
        chk("R8 single busy", m_busy, 16);
        run(16'h0070, 16'h0001, 16'h0000, 16'd1, 1'b1);
        chk("R5 dst wraps down", dst_out, 16'hFFFF);
    endtask

    task automatic t_count_zero();
        init_mem();
        irq = 1'b1;
        run(16'h00A0, 16'h0020, 16'h0060, 16'd0, 1'b0);
        irq = 1'b0;
        chk("R6 zero wraps", cnt_out, 16'hFFFF);
        chk("R9 ack", m_ack, 1);
        chk("R9 pc rewound", pc_out, 16'h00A0);
        chk("R9 busy till ack", m_busy, 21);
        chk("R5 src after one", src_out, 16'h0021);
    endtask

    task automatic t_irq_resume();
        init_mem();
        clr_mon(16'h00B0);
        pulse_start(16'h00B0, 16'h0030, 16'h0070, 16'd3, 1'b0);
        irq = 1'b1;
        wait_end();
        irq = 1'b0;
        chk("R9 ack mid copy", m_ack, 1);
        chk("R9 count left", cnt_out, 16'd2);
        run(pc_out, src_out, dst_out, cnt_out, 1'b0);
        chk("R9 resume done", m_done, 1);
        for (int i = 0; i < 3; i++) chk("R9 resumed byte", mem[8'h70 + i], pat(8'h30 + i));
        chk("R9 resume count", cnt_out, 0);
    endtask

    task automatic t_irq_ignored();
        init_mem();
        // Pulse during fetches only: misses the sampling point.
        clr_mon(16'h00C0);
        pulse_start(16'h00C0, 16'h0000, 16'h0080, 16'd2, 1'b0);
        irq = 1'b1;
        repeat (3) @(negedge clk);
        irq = 1'b0;
        wait_end();
        chk("R9 early pulse no ack", m_ack, 0);
        chk("R9 early pulse done", m_done, 1);
        // Request held through the final iteration.
        irq = 1'b1;
        run(16'h00C0, 16'h0004, 16'h0084, 16'd1, 1'b0);
        irq = 1'b0;
        chk("R10 final no ack", m_ack, 0);
        chk("R10 final done", m_done, 1);
    endtask

    task automatic t_start_busy();
        init_mem();
        clr_mon(16'h00D0);
        pulse_start(16'h00D0, 16'h0008, 16'h0048, 16'd2, 1'b0);
        repeat (10) @(negedge clk);
        pulse_start(16'h0010, 16'h0000, 16'h00E0, 16'd9, 1'b1);
        wait_end();
        chk("R12 busy cycles", m_busy, 37);
        chk("R12 src", src_out, 16'h000A);
        chk("R12 dst", dst_out, 16'h004A);
        chk("R12 pc", pc_out, 16'h00D2);
        chk("R12 untouched", mem[8'hE0], pat(8'hE0));
    endtask

    initial begin
        clr_mon(16'h0000);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_copy_up();
        t_copy_down();
        t_wrap();
        t_count_zero();
        t_irq_resume();
        t_irq_ignored();
        t_start_busy();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule